// File: doc/BRIEF.md
# Cell and Temperature Limit Monitor

This block watches the stream of conversion results from a battery-cell measurement front end. Each result enters as a valid strobe, a channel index and a 15-bit code. Channels 0 to 5 carry cell voltages and channels 6 to 12 carry auxiliary thermistor voltages. The result is checked against two limits held for its channel. A violation sets a sticky flag, and the flag stays set until software clears it.

Cell limits are 8-bit codes at 128 result LSBs per step. Auxiliary limits are 10-bit codes at 32 result LSBs per step. For the auxiliary channels the sense is inverted, because a thermistor voltage falls as the temperature rises. A low reading is over-temperature and a high reading is under-temperature. The number of populated cells can be set between 3 and 6, and an empty position never raises a flag. A registered fault request goes high whenever any set flag is also enabled. The host uses this request to drive a fault line, which has to respond within 56 µs of a detected violation.

Top module: `lim_mon_top`

## Requirements
- R1: After a synchronous reset, all flags and `fault_req` are 0, all enables are 1 and the cell count is 6. The default limits are cell over-voltage 215, cell under-voltage 128, auxiliary over-temperature 238 and auxiliary under-temperature 782.
- R2: For a cell channel (index 0 to 5), the code is result bits [14:7]. The up flag sets when the code is strictly greater than the channel's over-voltage limit. The down flag sets when the code is strictly less than the under-voltage limit. A code equal to either limit sets nothing.
- R3: For an auxiliary channel (index 6 to 12), the code is result bits [14:5]. The up flag (over-temperature) sets when the code is strictly less than the over-temperature limit. The down flag (under-temperature) sets when the code is strictly greater than the under-temperature limit. A code equal to either limit sets nothing.
- R4: The cell count is written to address 16, bits [2:0]. A value below 3 acts as 3 and a value above 6 acts as 6. A result on a cell channel whose index is at or above the effective count sets no flag.
- R5: Flags are sticky. A write to address 19 clears up flag i for each wdata bit i that is 1. A write to address 20 does the same for the down flags. Bits written as 0 leave their flags unchanged.
- R6: `fault_req` is 1 exactly when some up flag has its enable bit set or some down flag has its enable bit set. The up enables are at address 17 and the down enables at address 18, with bit i for channel i. After a violating result is sampled, the flag is visible at the second rising edge and `fault_req` at the third.
- R7: Writing address c (0 to 12) sets the limits of channel c. For a cell channel, wdata[7:0] is the over-voltage limit and wdata[15:8] is the under-voltage limit. For an auxiliary channel, wdata[9:0] is the over-temperature limit and wdata[19:10] is the under-temperature limit.
- R8: A result with a channel index of 13 or more changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Result strobe |
| res_chan | input | 4 | Result channel index |
| res_data | input | 15 | Result code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 20 | Register write data |
| up_flags | output | 13 | Sticky over-voltage / over-temperature flags, bit per channel |
| dn_flags | output | 13 | Sticky under-voltage / under-temperature flags, bit per channel |
| fault_req | output | 1 | Registered fault request |

## Verification
Cell results are applied at the limit code itself with all low bits set, and then one code past it. This separates a strict comparison from an inclusive one and shows that the truncated bits are ignored. Auxiliary results are applied on both sides of both limits, which exposes a comparison whose sense is not inverted or that uses the wrong bit slice. Cell-count writes of 3, 1 and 7 tell apart correct gating, missing clamping and an off-by-one at the count boundary. Enable toggling, partial and all-zero clears, rewritten limits and out-of-map channel indices then show that flags stay sticky, that the fault request follows the enables, and that each channel decodes its own limits.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int N_CELL_D     = 6;
  localparam int N_AUX_D      = 7;
  localparam int RES_W_D      = 15;
  localparam int CELL_LIM_W_D = 8;
  localparam int AUX_LIM_W_D  = 10;
  localparam int ADDR_W_D     = 5;
  localparam int WD_W_D       = 20;
  localparam int CNT_W_D      = 3;
  localparam int MIN_CELL_D   = 3;

  // register addresses above the per-channel limit window
  localparam int A_CFG    = 16;
  localparam int A_UP_EN  = 17;
  localparam int A_DN_EN  = 18;
  localparam int A_UP_CLR = 19;
  localparam int A_DN_CLR = 20;

  // reset codes: 4.2 V and 2.5 V at 19.53125 mV, 1.16 V and 3.82 V at 4.8828125 mV
  localparam int CELL_OV_RST = 215;
  localparam int CELL_UV_RST = 128;
  localparam int AUX_OT_RST  = 238;
  localparam int AUX_UT_RST  = 782;

  function automatic int clamp_cnt(int raw, int lo, int hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction
endpackage

// File: rtl/lim_regs.sv
module lim_regs
  import lim_pkg::*;
#(
  parameter int N_CELL     = N_CELL_D,
  parameter int N_AUX      = N_AUX_D,
  parameter int CELL_LIM_W = CELL_LIM_W_D,
  parameter int LIM_W      = AUX_LIM_W_D,
  parameter int ADDR_W     = ADDR_W_D,
  parameter int WD_W       = WD_W_D,
  parameter int CNT_W      = CNT_W_D,
  parameter int MIN_CELL   = MIN_CELL_D,
  localparam int NCH       = N_CELL + N_AUX,
  localparam int CH_W      = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WD_W-1:0]   reg_wdata,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [LIM_W-1:0]  rd_up,
  output logic [LIM_W-1:0]  rd_dn,
  output logic [NCH-1:0]    up_en,
  output logic [NCH-1:0]    dn_en,
  output logic [CNT_W-1:0]  cell_cnt,
  output logic [NCH-1:0]    clr_up,
  output logic [NCH-1:0]    clr_dn
);
  logic [LIM_W-1:0] up_lim [NCH];
  logic [LIM_W-1:0] dn_lim [NCH];
  logic [CNT_W-1:0] cnt_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        up_lim[i] <= (i < N_CELL) ? LIM_W'(CELL_OV_RST) : LIM_W'(AUX_OT_RST);
        dn_lim[i] <= (i < N_CELL) ? LIM_W'(CELL_UV_RST) : LIM_W'(AUX_UT_RST);
      end
    end else if (reg_wr) begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr == ADDR_W'(i)) begin
          if (i < N_CELL) begin
            up_lim[i] <= LIM_W'(reg_wdata[CELL_LIM_W-1:0]);
            dn_lim[i] <= LIM_W'(reg_wdata[2*CELL_LIM_W-1:CELL_LIM_W]);
          end else begin
            up_lim[i] <= reg_wdata[LIM_W-1:0];
            dn_lim[i] <= reg_wdata[2*LIM_W-1:LIM_W];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_raw <= CNT_W'(N_CELL);
      up_en   <= '1;
      dn_en   <= '1;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(A_CFG))   cnt_raw <= reg_wdata[CNT_W-1:0];
      if (reg_addr == ADDR_W'(A_UP_EN)) up_en   <= reg_wdata[NCH-1:0];
      if (reg_addr == ADDR_W'(A_DN_EN)) dn_en   <= reg_wdata[NCH-1:0];
    end
  end

  assign cell_cnt = CNT_W'(clamp_cnt(int'(cnt_raw), MIN_CELL, N_CELL));
  assign clr_up = (reg_wr && reg_addr == ADDR_W'(A_UP_CLR)) ? reg_wdata[NCH-1:0] : '0;
  assign clr_dn = (reg_wr && reg_addr == ADDR_W'(A_DN_CLR)) ? reg_wdata[NCH-1:0] : '0;

  always_comb begin
    rd_up = '0;
    rd_dn = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ch == CH_W'(i)) begin
        rd_up = up_lim[i];
        rd_dn = dn_lim[i];
      end
    end
  end
endmodule

// File: rtl/lim_cmp.sv
module lim_cmp
  import lim_pkg::*;
#(
  parameter int N_CELL     = N_CELL_D,
  parameter int N_AUX      = N_AUX_D,
  parameter int RES_W      = RES_W_D,
  parameter int CELL_LIM_W = CELL_LIM_W_D,
  parameter int LIM_W      = AUX_LIM_W_D,
  parameter int CNT_W      = CNT_W_D,
  localparam int NCH       = N_CELL + N_AUX,
  localparam int CH_W      = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [CH_W-1:0]  ch,
  input  logic [RES_W-1:0] data,
  input  logic [LIM_W-1:0] up_lim,
  input  logic [LIM_W-1:0] dn_lim,
  input  logic [CNT_W-1:0] cell_cnt,
  output logic             hit_vld,
  output logic [CH_W-1:0]  hit_ch,
  output logic             hit_up,
  output logic             hit_dn
);
  logic [CELL_LIM_W-1:0] cell_code;
  logic [LIM_W-1:0]      aux_code;
  logic                  is_cell, in_map, cell_on, up_c, dn_c;

  assign cell_code = data[RES_W-1 -: CELL_LIM_W];
  assign aux_code  = data[RES_W-1 -: LIM_W];

  always_comb begin
    is_cell = int'(ch) < N_CELL;
    in_map  = int'(ch) < NCH;
    cell_on = int'(ch) < int'(cell_cnt);
    if (is_cell) begin
      up_c = cell_code > up_lim[CELL_LIM_W-1:0];
      dn_c = cell_code < dn_lim[CELL_LIM_W-1:0];
    end else begin
      // thermistor: lower voltage means hotter
      up_c = aux_code < up_lim;
      dn_c = aux_code > dn_lim;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_vld <= 1'b0;
      hit_ch  <= '0;
      hit_up  <= 1'b0;
      hit_dn  <= 1'b0;
    end else begin
      hit_vld <= vld && in_map && (!is_cell || cell_on);
      hit_ch  <= ch;
      hit_up  <= up_c;
      hit_dn  <= dn_c;
    end
  end
endmodule

// File: rtl/lim_flags.sv
module lim_flags
  import lim_pkg::*;
#(
  parameter int NCH  = N_CELL_D + N_AUX_D,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit_vld,
  input  logic [CH_W-1:0] hit_ch,
  input  logic            hit_up,
  input  logic            hit_dn,
  input  logic [NCH-1:0]  clr_up,
  input  logic [NCH-1:0]  clr_dn,
  input  logic [NCH-1:0]  up_en,
  input  logic [NCH-1:0]  dn_en,
  output logic [NCH-1:0]  up_flags,
  output logic [NCH-1:0]  dn_flags,
  output logic            fault_req
);
  for (genvar i = 0; i < NCH; i++) begin : g_flag
    logic sel, up_b, dn_b;
    assign sel = hit_vld && (hit_ch == CH_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        up_b <= 1'b0;
        dn_b <= 1'b0;
      end else begin
        if (sel && hit_up)  up_b <= 1'b1;
        else if (clr_up[i]) up_b <= 1'b0;
        if (sel && hit_dn)  dn_b <= 1'b1;
        else if (clr_dn[i]) dn_b <= 1'b0;
      end
    end
    assign up_flags[i] = up_b;
    assign dn_flags[i] = dn_b;
  end

  always_ff @(posedge clk) begin
    if (rst) fault_req <= 1'b0;
    else     fault_req <= |((up_flags & up_en) | (dn_flags & dn_en));
  end
endmodule

// File: rtl/lim_mon_top.sv
module lim_mon_top
  import lim_pkg::*;
#(
  parameter int N_CELL     = N_CELL_D,
  parameter int N_AUX      = N_AUX_D,
  parameter int RES_W      = RES_W_D,
  parameter int CELL_LIM_W = CELL_LIM_W_D,
  parameter int LIM_W      = AUX_LIM_W_D,
  parameter int ADDR_W     = ADDR_W_D,
  parameter int WD_W       = WD_W_D,
  parameter int CNT_W      = CNT_W_D,
  parameter int MIN_CELL   = MIN_CELL_D,
  localparam int NCH       = N_CELL + N_AUX,
  localparam int CH_W      = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [RES_W-1:0]  res_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WD_W-1:0]   reg_wdata,
  output logic [NCH-1:0]    up_flags,
  output logic [NCH-1:0]    dn_flags,
  output logic              fault_req
);
  logic [LIM_W-1:0] rd_up, rd_dn;
  logic [NCH-1:0]   up_en, dn_en, clr_up, clr_dn;
  logic [CNT_W-1:0] cell_cnt;
  logic             hit_vld, hit_up, hit_dn;
  logic [CH_W-1:0]  hit_ch;

  lim_regs #(
    .N_CELL(N_CELL), .N_AUX(N_AUX), .CELL_LIM_W(CELL_LIM_W), .LIM_W(LIM_W),
    .ADDR_W(ADDR_W), .WD_W(WD_W), .CNT_W(CNT_W), .MIN_CELL(MIN_CELL)
  ) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_ch(res_chan), .rd_up(rd_up), .rd_dn(rd_dn), .up_en(up_en), .dn_en(dn_en),
    .cell_cnt(cell_cnt), .clr_up(clr_up), .clr_dn(clr_dn)
  );

  lim_cmp #(
    .N_CELL(N_CELL), .N_AUX(N_AUX), .RES_W(RES_W), .CELL_LIM_W(CELL_LIM_W),
    .LIM_W(LIM_W), .CNT_W(CNT_W)
  ) cmp_i (
    .clk(clk), .rst(rst), .vld(res_valid), .ch(res_chan), .data(res_data),
    .up_lim(rd_up), .dn_lim(rd_dn), .cell_cnt(cell_cnt),
    .hit_vld(hit_vld), .hit_ch(hit_ch), .hit_up(hit_up), .hit_dn(hit_dn)
  );

  lim_flags #(.NCH(NCH)) flags_i (
    .clk(clk), .rst(rst), .hit_vld(hit_vld), .hit_ch(hit_ch), .hit_up(hit_up),
    .hit_dn(hit_dn), .clr_up(clr_up), .clr_dn(clr_dn), .up_en(up_en), .dn_en(dn_en),
    .up_flags(up_flags), .dn_flags(dn_flags), .fault_req(fault_req)
  );
endmodule

// File: rtl/lim_mon_chk.sv
module lim_mon_chk
  import lim_pkg::*;
#(
  parameter int NCH    = N_CELL_D + N_AUX_D,
  parameter int CH_W   = $clog2(NCH),
  parameter int ADDR_W = ADDR_W_D
) (
  input logic              clk,
  input logic              rst,
  input logic              res_valid,
  input logic [CH_W-1:0]   res_chan,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NCH-1:0]    up_flags,
  input logic [NCH-1:0]    dn_flags,
  input logic              fault_req
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R5
  up_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == ADDR_W'(A_UP_CLR)) |=> ((up_flags & $past(up_flags)) == $past(up_flags)));

  // R5
  dn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == ADDR_W'(A_DN_CLR)) |=> ((dn_flags & $past(dn_flags)) == $past(dn_flags)));

  // R8
  up_source_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && ((up_flags & ~$past(up_flags)) != '0)) |->
      ($past(res_valid, 2) && int'($past(res_chan, 2)) < NCH));

  // R8
  dn_source_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && ((dn_flags & ~$past(dn_flags)) != '0)) |->
      ($past(res_valid, 2) && int'($past(res_chan, 2)) < NCH));

  // R6
  no_flag_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (up_flags == '0 && dn_flags == '0) |=> !fault_req);

  // R6
  fault_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $rose(fault_req)) |-> ($past(up_flags) != '0 || $past(dn_flags) != '0));
endmodule

bind lim_mon_top lim_mon_chk #(.NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .up_flags(up_flags), .dn_flags(dn_flags), .fault_req(fault_req)
);

// File: tb/lim_mon_top_tb_top.sv
module lim_mon_top_tb_top;
  localparam int NCH = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_valid = 1'b0;
  logic [3:0]  res_chan = '0;
  logic [14:0] res_data = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [NCH-1:0] up_flags, dn_flags;
  logic        fault_req;

  lim_mon_top dut_i (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .up_flags(up_flags), .dn_flags(dn_flags), .fault_req(fault_req)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nvec = 0;
  int nbad = 0;

  typedef struct {
    int             due;
    logic [NCH-1:0] up;
    logic [NCH-1:0] dn;
    logic           flt;
    string          tag;
  } exp_t;
  exp_t q[$];

  // reference state built from the requirements
  logic [NCH-1:0] m_up = '0, m_dn = '0, m_upen = '1, m_dnen = '1;
  int m_cnt = 6;
  int m_hi[NCH];
  int m_lo[NCH];

  function automatic int eff_cnt();
    if (m_cnt < 3) return 3;
    if (m_cnt > 6) return 6;
    return m_cnt;
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.due = cyc + 3;
    e.up  = m_up;
    e.dn  = m_dn;
    e.flt = |((m_up & m_upen) | (m_dn & m_dnen));
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic gap();
    @(negedge clk);
    res_valid = 1'b0;
    reg_wr    = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(int ch, int data, string tag);
    int code;
    res_valid = 1'b1;
    res_chan  = 4'(ch);
    res_data  = 15'(data);
    if (ch < 6) begin
      if (ch < eff_cnt()) begin
        code = (data >> 7) & 255;
        if (code > m_hi[ch]) m_up[ch] = 1'b1;
        if (code < m_lo[ch]) m_dn[ch] = 1'b1;
      end
    end else if (ch < NCH) begin
      code = (data >> 5) & 1023;
      if (code < m_hi[ch]) m_up[ch] = 1'b1;
      if (code > m_lo[ch]) m_dn[ch] = 1'b1;
    end
    push(tag);
    gap();
  endtask

  task automatic wr(int addr, int wd, string tag);
    reg_wr    = 1'b1;
    reg_addr  = 5'(addr);
    reg_wdata = 20'(wd);
    if (addr < 6) begin
      m_hi[addr] = wd & 255;
      m_lo[addr] = (wd >> 8) & 255;
    end else if (addr < NCH) begin
      m_hi[addr] = wd & 1023;
      m_lo[addr] = (wd >> 10) & 1023;
    end else if (addr == 16) m_cnt = wd & 7;
    else if (addr == 17) m_upen = wd[NCH-1:0];
    else if (addr == 18) m_dnen = wd[NCH-1:0];
    else if (addr == 19) m_up = m_up & ~wd[NCH-1:0];
    else if (addr == 20) m_dn = m_dn & ~wd[NCH-1:0];
    push(tag);
    gap();
  endtask

  task automatic clear_all();
    wr(19, 20'h01FFF, "R5 clear up");
    wr(20, 20'h01FFF, "R5 clear dn");
  endtask

  // monitor: compares each expected item when it falls due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      nvec++;
      if (up_flags !== e.up || dn_flags !== e.dn || fault_req !== e.flt) begin
        nbad++;
        $display("FAIL %s: up=%h dn=%h flt=%b expected up=%h dn=%h flt=%b",
                 e.tag, up_flags, dn_flags, fault_req, e.up, e.dn, e.flt);
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_hi[i] = (i < 6) ? 215 : 238;
      m_lo[i] = (i < 6) ? 128 : 782;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    nvec++;
    if (up_flags !== '0 || dn_flags !== '0 || fault_req !== 1'b0) begin
      nbad++;
      $display("FAIL R1 reset: up=%h dn=%h flt=%b expected 0 0 0", up_flags, dn_flags, fault_req);
    end

    // R2 over-voltage edge, low bits ignored
    send(0, (215 << 7) | 127, "R1 R2 cell at OV limit");
    send(0, 216 << 7, "R2 cell above OV limit");
    send(0, 150 << 7, "R5 sticky after normal value");
    wr(19, 0, "R5 zero clear has no effect");
    wr(19, 1, "R5 clear up ch0");
    // R2 under-voltage edge
    send(1, 128 << 7, "R2 cell at UV limit");
    send(1, (127 << 7) | 127, "R2 cell below UV limit");
    wr(20, 2, "R5 clear dn ch1");
    // R3 inverted auxiliary sense
    send(6, 238 << 5, "R1 R3 aux at OT limit");
    send(6, (237 << 5) | 31, "R3 aux below OT limit");
    send(7, (782 << 5) | 31, "R3 aux at UT limit");
    send(7, 783 << 5, "R3 aux above UT limit");
    clear_all();

    // R6 latency probe and enables
    res_valid = 1'b1; res_chan = 4'd2; res_data = 15'(220 << 7);
    m_up[2] = 1'b1;
    push("R6 fault after third edge");
    @(negedge clk);
    res_valid = 1'b0;
    @(negedge clk);
    nvec++;
    if (up_flags[2] !== 1'b1 || fault_req !== 1'b0) begin
      nbad++;
      $display("FAIL R6 latency: flag=%b flt=%b expected flag=1 flt=0", up_flags[2], fault_req);
    end
    repeat (2) @(negedge clk);
    wr(17, 20'h01FFB, "R6 up enable off masks fault");
    wr(17, 20'h01FFF, "R6 up enable on restores fault");
    wr(18, 0, "R6 dn enables off");
    send(3, 10 << 7, "R6 dn flag with dn disabled");
    wr(18, 20'h01FFF, "R6 dn enables on");
    clear_all();

    // R4 cell count gating and clamping
    wr(16, 3, "R4 count 3");
    send(4, 220 << 7, "R4 ch4 unused");
    send(3, 10 << 7, "R4 ch3 unused at count 3");
    send(2, 220 << 7, "R4 ch2 in use");
    wr(16, 1, "R4 count 1 clamps to 3");
    send(3, 220 << 7, "R4 ch3 unused after clamp");
    send(2, 10 << 7, "R4 ch2 in use after clamp");
    wr(16, 7, "R4 count 7 clamps to 6");
    send(5, 220 << 7, "R4 ch5 in use at 6");
    clear_all();

    // R7 per-channel limit writes
    wr(3, (50 << 8) | 100, "R7 ch3 limits");
    send(3, 100 << 7, "R7 ch3 at new OV");
    send(3, 101 << 7, "R7 ch3 above new OV");
    send(3, 49 << 7, "R7 ch3 below new UV");
    send(0, 216 << 7, "R7 ch0 keeps default");
    wr(12, (900 << 10) | 300, "R7 ch12 limits");
    send(12, 300 << 5, "R7 ch12 at new OT");
    send(12, 299 << 5, "R7 ch12 below new OT");
    send(12, 901 << 5, "R7 ch12 above new UT");
    clear_all();

    // R8 out-of-map channels
    send(13, 0, "R8 ch13 ignored");
    send(15, 15'h7FFF, "R8 ch15 ignored");
    send(14, 0, "R8 ch14 ignored");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    report();
    $finish;
  end
endmodule